// File: doc/BRIEF.md
# SPI Byte Controller (Master or Slave)

This block moves one byte at a time over a four-wire serial peripheral interface. Software drives it through four byte-wide registers: control, status, data and a clock/fault configuration register. As a master it makes the serial clock from the system clock through a programmable divider, shifts the byte out on the master-out line and captures the master-in line. It can also drive a slave-select strobe around each byte. As a slave it follows an external clock and select, and drives the slave-out line only while it is selected.

The clock's idle level, the clock edge on which data is captured and the order of bits on the wire are all selectable. The data register always holds the byte with its most significant bit in bit 7, whatever the wire order. The block raises one interrupt line from three flags: byte complete, mode fault and transmit buffer empty. In master mode a mode fault is detected when another device pulls the select line low. A fault drops the block out of master mode and releases its clock and data drivers.

Top module: `spi_ctl`

## Requirements
- R1: After reset the control register (address 0) and configuration register (address 3) read 0x00, and the status register (address 1) reads 0x20. Status holds the complete flag in bit 7, the empty flag in bit 5 and the fault flag in bit 4. No clock, data or select driver is enabled and the interrupt is low.
- R2: Control bits are, from 7 to 0: interrupt enable, block enable, empty-interrupt enable, master, clock polarity, clock phase, select-output enable, LSB-first. In master mode a byte written to data (address 2) goes out on mosi_o, LSB first when bit 0 is 1 and MSB first otherwise. The byte sampled on miso_i is then readable at address 2 with its MSB in bit 7, and the complete flag is set.
- R3: With polarity 0 the master clock rests low, and with polarity 1 it rests high.
- R4: With phase 0 data is captured on clock edges 1, 3, …, 15 of the 16-edge byte. With phase 1 it is captured on edges 2, 4, …, 16.
- R5: In slave mode, with ss_i low, the block clocks on sck_i under the same polarity, phase and order rules. It drives miso_o (miso_oe high) only while ss_i is low, and sets the complete flag after the 16th edge.
- R6: A data write while the empty flag is 1 queues the byte and clears the flag. The flag returns to 1 when the byte enters the shifter. A data write while the flag is 0 is dropped.
- R7: Reading status while the complete flag is 1, and then reading data, clears the flag.
- R8: Configuration bit 7 is fault enable and bits 3:0 are a divider D. Each master clock half period lasts D+1 system clocks. With fault enable and select-output enable both set in master mode, ss_oe is 1. ss_o then falls one half period before the first edge and rises one half period after the last edge.
- R9: In master mode with fault enable set, select-output enable clear and ss_i low, the fault flag is set and the master bit clears, which drops sck_oe and mosi_oe. A status read with the fault flag set, followed by a control write, clears the flag.
- R10: In master mode, a control write that changes the master, polarity, phase, select-output or LSB-first bit stops the byte in flight. The clock returns to rest, ss_o goes high and no completion follows.
- R11: Clearing the enable bit resets the complete and fault flags, sets the empty flag and discards a queued byte.
- R12: irq is high when interrupt enable is set and the complete or fault flag is set. It is also high when empty-interrupt enable is set and the empty flag is set.
- R13: Consecutive master clock edges are D+1 system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives flag clearing) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Master serial clock out |
| sck_oe | output | 1 | Serial clock driver enable |
| mosi_o | output | 1 | Master-out data |
| mosi_oe | output | 1 | Master-out driver enable |
| miso_i | input | 1 | Master-in data |
| sck_i | input | 1 | Slave serial clock in |
| mosi_i | input | 1 | Slave data in |
| ss_i | input | 1 | Select input (active low) |
| miso_o | output | 1 | Slave-out data |
| miso_oe | output | 1 | Slave-out driver enable |
| ss_o | output | 1 | Select strobe out (active low) |
| ss_oe | output | 1 | Select strobe driver enable |

## Verification
Two functions can land on the same clock edge. The first is a byte finishing while the next queued byte starts. The bench writes three bytes back to back with master loopback. It then checks that the first two come back in order with the correct empty-flag behaviour, and that the third, which arrived while the queue was full, never appears. The second is a control write that lands in the middle of a byte. The bench changes the phase bit mid-transfer and checks that the clock returns to rest, that the select strobe rises and that no complete flag follows.

// File: rtl/spi_ctl_pkg.sv
// Shared constants for the SPI byte controller: register addresses and
// bit positions. Assumes an 8-bit register file on a 2-bit address.
package spi_ctl_pkg;
    localparam int BYTE_W = 8;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_CFG  = 2'd3;

    // control bits
    localparam int C_IE  = 7;
    localparam int C_EN  = 6;
    localparam int C_TIE = 5;
    localparam int C_MST = 4;
    localparam int C_POL = 3;
    localparam int C_PHA = 2;
    localparam int C_SSO = 1;
    localparam int C_LSB = 0;

    // configuration bits
    localparam int G_FEN = 7;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LEAD,
        SEQ_RUN,
        SEQ_TRAIL
    } seq_state_t;
endpackage

// File: rtl/spi_ctl_sync.sv
// Multi-stage synchronizer for one asynchronous input bit.
// Assumes STAGES >= 2; RST_VAL is the value held during reset.
module spi_ctl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] r_q;

    // shift the input through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= {STAGES{RST_VAL}};
        else        r_q <= {r_q[STAGES-2:0], d};
    end

    assign q = r_q[STAGES-1];
endmodule

// File: rtl/spi_ctl_shift.sv
// Bit engine shared by master and slave: holds the outgoing byte, counts
// clock edges and places received bits straight into their final position.
// Assumes edge_ev pulses once per serial clock edge and load starts a byte.
module spi_ctl_shift #(
    parameter int W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [W-1:0]               load_data,
    input  logic                       edge_ev,
    input  logic                       cpha,
    input  logic                       lsbfe,
    input  logic                       din,
    output logic                       dout,
    output logic [$clog2(2*W):0]       edge_cnt,
    output logic [W-1:0]               rx_data
);
    localparam int CW = $clog2(2*W) + 1;
    localparam int IW = $clog2(W);
    localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

    logic [W-1:0]  tx_q;
    logic [W-1:0]  rx_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] half;
    logic [IW-1:0] idx;
    logic          sample_now;

    // bit number currently on the wire, derived from the edge count
    always_comb begin
        if (cpha) half = (cnt_q == '0) ? '0 : (cnt_q - 1'b1) >> 1;
        else      half = cnt_q >> 1;
    end

    assign idx        = lsbfe ? half[IW-1:0] : TOP_IDX - half[IW-1:0];
    assign sample_now = cpha ? cnt_q[0] : ~cnt_q[0];

    // load a byte, then count edges and capture on sampling edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= '0;
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            tx_q  <= load_data;
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (edge_ev) begin
            cnt_q <= cnt_q + 1'b1;
            if (sample_now) rx_q[idx] <= din;
        end
    end

    assign dout     = tx_q[idx];
    assign edge_cnt = cnt_q;
    assign rx_data  = rx_q;
endmodule

// File: rtl/spi_ctl_mseq.sv
// Master timing: divider, select lead-in, EDGES clock edges, select
// tail-out. Assumes div is stable while a byte runs; abort wins over all.
module spi_ctl_mseq
    import spi_ctl_pkg::*;
#(
    parameter int DIV_W = 4,
    parameter int EDGES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [DIV_W-1:0] div,
    output logic             sck_lvl,
    output logic             edge_ev,
    output logic             done,
    output logic             ss_n,
    output logic             busy
);
    localparam int EW = $clog2(EDGES + 1);
    localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

    seq_state_t       st_q;
    logic [DIV_W-1:0] cnt_q;
    logic [EW-1:0]    edges_q;
    logic             sck_q;
    logic             tick;

    assign tick = (cnt_q == div);

    // phase sequencing with one edge per divider tick
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            st_q    <= SEQ_IDLE;
            cnt_q   <= '0;
            edges_q <= '0;
            sck_q   <= 1'b0;
        end else begin
            case (st_q)
                SEQ_IDLE: if (start) begin
                    st_q    <= SEQ_LEAD;
                    cnt_q   <= '0;
                    edges_q <= '0;
                end
                SEQ_LEAD, SEQ_RUN: if (tick) begin
                    cnt_q   <= '0;
                    sck_q   <= ~sck_q;
                    edges_q <= edges_q + 1'b1;
                    st_q    <= (edges_q == LAST) ? SEQ_TRAIL : SEQ_RUN;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: if (tick) begin
                    st_q  <= SEQ_IDLE;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            endcase
        end
    end

    assign edge_ev = (st_q == SEQ_LEAD || st_q == SEQ_RUN) && tick && !abort;
    assign done    = (st_q == SEQ_TRAIL) && tick && !abort;
    assign ss_n    = (st_q == SEQ_IDLE);
    assign busy    = (st_q != SEQ_IDLE);
    assign sck_lvl = sck_q;
endmodule

// File: rtl/spi_ctl.sv
// SPI byte controller top: register file, flags, interrupt, mode fault and
// pin enables around the shared bit engine and the master sequencer.
// Assumes sck_i, ss_i are asynchronous and mosi_i/miso_i are stable around
// the sampling edges; external pads combine *_o with *_oe.
module spi_ctl
    import spi_ctl_pkg::*;
#(
    parameter int DIV_W  = 4,
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       sck_o,
    output logic       sck_oe,
    output logic       mosi_o,
    output logic       mosi_oe,
    input  logic       miso_i,
    input  logic       sck_i,
    input  logic       mosi_i,
    input  logic       ss_i,
    output logic       miso_o,
    output logic       miso_oe,
    output logic       ss_o,
    output logic       ss_oe
);
    localparam int EDGES = 2 * BYTE_W;
    localparam int CW    = $clog2(EDGES) + 1;
    localparam logic [CW-1:0] LAST_EDGE = CW'(EDGES - 1);

    logic [7:0] ctrl_q, cfg_q, tx_buf_q, rbuf_q;
    logic       done_q, fault_q, txe_q, pend_q, done_arm_q, fault_arm_q;
    logic       sck_d_q, ss_d_q, s_done_q;
    logic       sck_s, ss_s;
    logic       wr_ctrl, wr_data, rd_stat, rd_data;
    logic       cfg_change, fault_hit, abort, m_start, slave_act;
    logic       s_edge, s_load, sh_load, sh_edge, sh_dout, complete;
    logic       m_sck, m_edge, m_done, m_ss_n, m_busy;
    logic [CW-1:0]     sh_cnt;
    logic [BYTE_W-1:0] sh_rx;

    spi_ctl_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s));
    spi_ctl_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync_ss (
        .clk(clk), .rst_n(rst_n), .d(ss_i), .q(ss_s));

    assign wr_ctrl = wr_en && addr == A_CTRL;
    assign wr_data = wr_en && addr == A_DATA;
    assign rd_stat = rd_en && addr == A_STAT;
    assign rd_data = rd_en && addr == A_DATA;

    assign cfg_change = wr_ctrl && (wdata[C_MST] != ctrl_q[C_MST] || !wdata[C_EN] ||
                        (ctrl_q[C_MST] && wdata[C_POL:C_LSB] != ctrl_q[C_POL:C_LSB]));
    assign fault_hit  = ctrl_q[C_EN] && ctrl_q[C_MST] && cfg_q[G_FEN] &&
                        !ctrl_q[C_SSO] && !ss_s;
    assign abort      = !ctrl_q[C_EN] || cfg_change || fault_hit;
    assign m_start    = ctrl_q[C_EN] && ctrl_q[C_MST] && pend_q && !m_busy && !abort;
    assign slave_act  = ctrl_q[C_EN] && !ctrl_q[C_MST] && !ss_s;
    assign s_edge     = slave_act && (sck_s ^ sck_d_q);
    assign s_load     = ctrl_q[C_EN] && !ctrl_q[C_MST] && ss_d_q && !ss_s;
    assign sh_load    = m_start || s_load;
    assign sh_edge    = ctrl_q[C_MST] ? m_edge : s_edge;
    assign complete   = ctrl_q[C_MST] ? m_done : s_done_q;

    spi_ctl_mseq #(.DIV_W(DIV_W), .EDGES(EDGES)) u_mseq (
        .clk(clk), .rst_n(rst_n), .start(m_start), .abort(abort),
        .div(cfg_q[DIV_W-1:0]), .sck_lvl(m_sck), .edge_ev(m_edge),
        .done(m_done), .ss_n(m_ss_n), .busy(m_busy));

    spi_ctl_shift #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load),
        .load_data(pend_q ? tx_buf_q : '0), .edge_ev(sh_edge),
        .cpha(ctrl_q[C_PHA]), .lsbfe(ctrl_q[C_LSB]),
        .din(ctrl_q[C_MST] ? miso_i : mosi_i),
        .dout(sh_dout), .edge_cnt(sh_cnt), .rx_data(sh_rx));

    // control and configuration registers; a fault drops the master bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_en && addr == A_CFG) cfg_q <= wdata;
            if (fault_hit) ctrl_q[C_MST] <= 1'b0;
        end
    end

    // slave edge history and registered slave completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d_q  <= 1'b0;
            ss_d_q   <= 1'b1;
            s_done_q <= 1'b0;
        end else begin
            sck_d_q  <= sck_s;
            ss_d_q   <= ss_s;
            s_done_q <= s_edge && sh_cnt == LAST_EDGE;
        end
    end

    // transmit queue and empty flag
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_q[C_EN]) begin
            txe_q  <= 1'b1;
            pend_q <= 1'b0;
            if (!rst_n) tx_buf_q <= '0;
        end else if (sh_load && pend_q) begin
            txe_q  <= 1'b1;
            pend_q <= 1'b0;
        end else if (wr_data && txe_q) begin
            tx_buf_q <= wdata;
            pend_q   <= 1'b1;
            txe_q    <= 1'b0;
        end
    end

    // complete flag, read buffer and the status-then-data clear sequence
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_q[C_EN]) begin
            done_q     <= 1'b0;
            done_arm_q <= 1'b0;
            if (!rst_n) rbuf_q <= '0;
        end else if (complete) begin
            done_q <= 1'b1;
            rbuf_q <= sh_rx;
        end else if (rd_data && done_arm_q) begin
            done_q     <= 1'b0;
            done_arm_q <= 1'b0;
        end else if (rd_stat && done_q) begin
            done_arm_q <= 1'b1;
        end
    end

    // fault flag and the status-then-control clear sequence
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_q[C_EN]) begin
            fault_q     <= 1'b0;
            fault_arm_q <= 1'b0;
        end else if (fault_hit) begin
            fault_q <= 1'b1;
        end else if (wr_ctrl && fault_arm_q) begin
            fault_q     <= 1'b0;
            fault_arm_q <= 1'b0;
        end else if (rd_stat && fault_q) begin
            fault_arm_q <= 1'b1;
        end
    end

    // register read mux
    always_comb begin
        case (addr)
            A_CTRL:  rdata = ctrl_q;
            A_STAT:  rdata = {done_q, 1'b0, txe_q, fault_q, 4'b0000};
            A_DATA:  rdata = rbuf_q;
            default: rdata = cfg_q;
        endcase
    end

    assign irq     = (ctrl_q[C_IE] && (done_q || fault_q)) || (ctrl_q[C_TIE] && txe_q);
    assign sck_o   = ctrl_q[C_POL] ^ m_sck;
    assign sck_oe  = ctrl_q[C_EN] && ctrl_q[C_MST];
    assign mosi_o  = sh_dout;
    assign mosi_oe = ctrl_q[C_EN] && ctrl_q[C_MST];
    assign miso_o  = sh_dout;
    assign miso_oe = slave_act;
    assign ss_o    = m_ss_n;
    assign ss_oe   = ctrl_q[C_EN] && ctrl_q[C_MST] && cfg_q[G_FEN] && ctrl_q[C_SSO];
endmodule

// File: rtl/spi_ctl_chk.sv
// Temporal checks on the SPI byte controller, bound into every instance.
// Assumes the top's internal register and flag names.
module spi_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctrl_q,
    input logic       txe_q,
    input logic       done_q,
    input logic       fault_q,
    input logic       m_busy,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic       sck_o,
    input logic       ss_o
);
    // R11: a disabled block shows clean flags one cycle later
    p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[6] |=> (!done_q && !fault_q && txe_q));

    // R3: an idle master rests its clock at the polarity level
    p_sck_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[4] && !m_busy) |-> (sck_o == ctrl_q[3]));

    // R6: an accepted data write empties the flag on the next cycle
    p_write_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2 && txe_q && ctrl_q[6]) |=> !txe_q);

    // R9: a new fault always leaves the block out of master mode
    p_fault_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> !ctrl_q[4]);

    // R8: a master byte completes with the select strobe released
    p_ss_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_q) && ctrl_q[4]) |-> ss_o);
endmodule

bind spi_ctl spi_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .txe_q(txe_q),
    .done_q(done_q), .fault_q(fault_q), .m_busy(m_busy),
    .wr_en(wr_en), .addr(addr), .sck_o(sck_o), .ss_o(ss_o));

// File: tb/spi_ctl_bench.sv
// Sweeps every clock mode and bit order in master and slave roles, then
// runs the queue, abort, fault, disable and interrupt corner cases.
module spi_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;
    logic       miso_i;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_i = 1'b1;
    logic       loop_en = 1'b0, miso_drv = 1'b0;
    int         n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;
    assign miso_i = loop_en ? mosi_o : miso_drv;

    spi_ctl u_spi_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .sck_i(sck_i),
        .mosi_i(mosi_i), .ss_i(ss_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_o(ss_o), .ss_oe(ss_oe));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_irq(input int limit);
        int t = 0;
        while (!irq && t < limit) begin @(negedge clk); t++; end
    endtask

    // master transfer against a bench slave model
    task automatic mxfer(input bit pol, input bit pha, input bit lsb,
                         input logic [7:0] txb, input logic [7:0] slvb, input int dv);
        logic [7:0] rec = 8'h00, v;
        int edges = 0, t = 0, fall_t = 0, rise_t = 0, last_t = 0;
        logic prev_sck, prev_ss;
        wr(2'd3, 8'h80 | 8'(dv));
        wr(2'd0, 8'hD2 | {4'b0, pol, pha, 1'b0, lsb});
        @(negedge clk);
        chk("R3 rest level before byte", sck_o, pol);
        chk("R8 select driver enabled", ss_oe, 1);
        miso_drv = lsb ? slvb[0] : slvb[7];
        prev_sck = sck_o; prev_ss = ss_o;
        addr = 2'd2; wdata = txb; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        while (!irq && t < 4000) begin
            @(negedge clk); t++;
            if (prev_ss && !ss_o) fall_t = t;
            if (!prev_ss && ss_o) rise_t = t;
            if (sck_o != prev_sck) begin
                edges++;
                if (edges == 1) chk("R8 select lead time", t - fall_t, dv + 1);
                else            chk("R13 edge spacing", t - last_t, dv + 1);
                last_t = t;
                if (pha ? (edges % 2 == 0) : (edges % 2 == 1)) begin
                    int j = (edges - 1) / 2;
                    rec[lsb ? j : 7 - j] = mosi_o;
                end else begin
                    int j = pha ? (edges - 1) / 2 : edges / 2;
                    if (j < 8) miso_drv = lsb ? slvb[j] : slvb[7 - j];
                end
            end
            prev_sck = sck_o; prev_ss = ss_o;
        end
        chk("R4 edge count per byte", edges, 16);
        chk("R8 select tail time", rise_t - last_t, dv + 1);
        chk("R3 rest level after byte", sck_o, pol);
        chk("R2 wire byte sent", rec, txb);
        rd(2'd1, v); chk("R2 complete flag set", v, 8'hA0);
        rd(2'd2, v); chk("R2 received byte", v, slvb);
        rd(2'd1, v); chk("R7 flag cleared", v, 8'h20);
        chk("R12 irq low after clear", irq, 0);
    endtask

    // slave transfer driven by a bench master model
    task automatic sxfer(input bit pol, input bit pha, input bit lsb,
                         input logic [7:0] sb, input logic [7:0] mb);
        logic [7:0] rec = 8'h00, v;
        wr(2'd0, 8'hC0 | {4'b0, pol, pha, 1'b0, lsb});
        sck_i = pol; ss_i = 1'b1; mosi_i = 1'b0;
        wr(2'd2, sb);
        @(negedge clk);
        chk("R5 slave out released when deselected", miso_oe, 0);
        ss_i = 1'b0;
        repeat (8) @(negedge clk);
        chk("R5 slave out driven when selected", miso_oe, 1);
        if (!pha) mosi_i = lsb ? mb[0] : mb[7];
        for (int k = 1; k <= 16; k++) begin
            bit samp = pha ? (k % 2 == 0) : (k % 2 == 1);
            if (samp) begin
                int j = (k - 1) / 2;
                rec[lsb ? j : 7 - j] = miso_o;
            end
            sck_i = ~sck_i;
            if (!samp) begin
                int j = pha ? (k - 1) / 2 : k / 2;
                if (j < 8) mosi_i = lsb ? mb[j] : mb[7 - j];
            end
            repeat (8) @(negedge clk);
        end
        ss_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5 slave complete irq", irq, 1);
        chk("R5 slave wire byte", rec, sb);
        rd(2'd1, v); chk("R5 slave complete flag", v, 8'hA0);
        rd(2'd2, v); chk("R5 slave received byte", v, mb);
        rd(2'd1, v); chk("R7 slave flag cleared", v, 8'h20);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk("R1 control reset", v, 8'h00);
        rd(2'd1, v); chk("R1 status reset", v, 8'h20);
        rd(2'd3, v); chk("R1 config reset", v, 8'h00);
        chk("R1 irq reset", irq, 0);
        chk("R1 clock driver off", sck_oe, 0);
        chk("R1 slave driver off", miso_oe, 0);

        // R2 R3 R4 R8 R13 master sweep
        for (int m = 0; m < 8; m++) begin
            for (int b = 0; b < 4; b++) begin
                logic [7:0] txb = 8'(8'hA5 + b * 61 + m * 17);
                logic [7:0] slvb = ~txb ^ 8'(m * 29);
                mxfer(m[2], m[1], m[0], txb, slvb, (m + b) % 3);
            end
        end

        // R5 slave sweep
        for (int m = 0; m < 8; m++) begin
            for (int b = 0; b < 2; b++) begin
                sxfer(m[2], m[1], m[0], 8'(8'h3C + m * 37 + b * 90), 8'(8'hC3 ^ (m * 11 + b * 70)));
            end
        end

        // R6 queue: third write lands while the queue is full and is dropped
        loop_en = 1'b1;
        wr(2'd3, 8'h03);
        wr(2'd0, 8'hD0);
        wr(2'd2, 8'h11);
        wr(2'd2, 8'h22);
        rd(2'd1, v); chk("R6 queue full flag", v, 8'h00);
        wr(2'd2, 8'h33);
        wait_irq(2000);
        rd(2'd1, v);
        rd(2'd2, v); chk("R6 first queued byte", v, 8'h11);
        wait_irq(2000);
        rd(2'd1, v); chk("R6 second completion with empty", v, 8'hA0);
        rd(2'd2, v); chk("R6 second queued byte", v, 8'h22);
        repeat (300) @(negedge clk);
        rd(2'd1, v); chk("R6 dropped write caused no byte", v, 8'h20);

        // R10 abort by phase change mid-byte
        wr(2'd3, 8'h07);
        wr(2'd0, 8'h50);
        wr(2'd2, 8'h96);
        repeat (20) @(negedge clk);
        chk("R10 byte in flight", ss_o, 0);
        wr(2'd0, 8'h54);
        chk("R10 select released", ss_o, 1);
        chk("R10 clock at rest", sck_o, 0);
        repeat (300) @(negedge clk);
        rd(2'd1, v); chk("R10 no completion", v, 8'h20);

        // R11 disable wipes a pending complete flag
        wr(2'd3, 8'h01);
        wr(2'd0, 8'h50);
        wr(2'd2, 8'h5A);
        repeat (100) @(negedge clk);
        rd(2'd1, v); chk("R11 flag set before disable", v, 8'hA0);
        wr(2'd0, 8'h10);
        rd(2'd1, v); chk("R11 flags after disable", v, 8'h20);

        // R12 interrupt sources
        wr(2'd0, 8'h60); @(negedge clk);
        chk("R12 empty interrupt", irq, 1);
        wr(2'd0, 8'h40); @(negedge clk);
        chk("R12 no enable no irq", irq, 0);
        wr(2'd0, 8'h50);
        wr(2'd2, 8'hE7);
        repeat (100) @(negedge clk);
        chk("R12 complete without enable", irq, 0);
        wr(2'd0, 8'hD0); @(negedge clk);
        chk("R12 complete with enable", irq, 1);
        rd(2'd1, v);
        rd(2'd2, v); chk("R2 loopback byte", v, 8'hE7);
        loop_en = 1'b0;

        // R9 mode fault
        ss_i = 1'b0;
        wr(2'd3, 8'h80);
        wr(2'd0, 8'hD0);
        repeat (4) @(negedge clk);
        rd(2'd1, v); chk("R9 fault flag", v, 8'h30);
        rd(2'd0, v); chk("R9 master bit cleared", v, 8'hC0);
        chk("R9 clock driver released", sck_oe, 0);
        chk("R9 data driver released", mosi_oe, 0);
        chk("R12 fault irq", irq, 1);
        ss_i = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd0, 8'hD0);
        repeat (4) @(negedge clk);
        rd(2'd1, v); chk("R9 fault cleared", v, 8'h20);
        chk("R9 master drivers back", sck_oe, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule